// File: doc/BRIEF.md
# Multi-Event Acquisition Buffer Manager

This block keeps the accounts for one channel's sample memory. The memory is split into a run-time number of event buffers, and each buffer holds a fixed window of `WIN_LEN` samples. While it is armed, the block writes incoming samples in a circle inside the current buffer. An accepted trigger starts a countdown of a programmed number of further samples. When the countdown ends, the block freezes that buffer, holds it for readout and moves on to the next buffer in ring order in the very next cycle. The readout side releases frozen buffers one at a time, oldest first, with a single-cycle release pulse.

Filled buffers are counted. The count drives three outputs: `full`, which stops trigger acceptance, `busy`, an early warning set at a programmable level, and `ev_ready`. There are two full modes. In halting mode the block is full when every buffer is frozen. It then discards samples, and after a release it must write a whole window again before it takes a new trigger. In spare mode the block is full one buffer earlier. It keeps writing into the last free buffer, so a trigger can be taken in the first cycle after a release.

The acquisition sequencer has four states. `ST_FILL` writes a fresh window and accepts no trigger. `ST_ARMED` writes samples and accepts triggers. `ST_POST` counts the post-trigger samples. `ST_HALT` discards samples. The transitions are:
- **window-complete**: FILL to ARMED on the `WIN_LEN`-th write.
- **trigger-accept**: ARMED to POST.
- **freeze**: POST to ARMED on the last post-trigger write.
- **halt**: FILL or ARMED to HALT when full in halting mode.
- **restart**: HALT to FILL once full clears.

Top module: `evbuf_mgr`

## Requirements
- R1: After reset `fill_level` is 0, `full`, `busy` and `ev_ready` are 0, and `wr_buf` and `rd_buf` are 0.
- R2: After reset, a trigger is ignored (`trig_acc` low) until `WIN_LEN` samples have been written. After that, a trigger while not full gives `trig_acc` high in the same cycle, and the sample of that cycle is still a pre-trigger sample.
- R3: After an accepted trigger, the next `cfg_post` written samples (1 to `WIN_LEN`) go into the current buffer, and cycles with `smp_valid` low do not count. The buffer is frozen on the last of them. In the next cycle `wr_buf` has advanced by one modulo `cfg_nbuf`, `wr_off` is 0, and a trigger can be accepted there.
- R4: A trigger during the post-trigger countdown is ignored.
- R5: `fill_level` rises by one per freeze and falls by one per `rel` pulse. A freeze and a release in the same cycle leave it unchanged. A release while `fill_level` is 0 is ignored.
- R6: `rd_buf` names the oldest frozen buffer and advances by one modulo `cfg_nbuf` on each effective release. `ev_ready` is high exactly while `fill_level` is nonzero.
- R7: With `cfg_spare`=0, `full` is high when `fill_level` equals `cfg_nbuf`. While it is high, triggers are rejected and no sample is written (`wr_en` low).
- R8: With `cfg_spare`=0, `full` falls in the cycle after a release. No sample is written in the cycle in which it falls. Triggers are then rejected until `WIN_LEN` further samples have been written, and the next trigger after that is accepted.
- R9: With `cfg_spare`=1 (legal for `cfg_nbuf` of 2 or more), `full` is high when `fill_level` is at least `cfg_nbuf`-1. Samples are still written into the current buffer and triggers are rejected. A trigger is accepted in the first cycle in which `full` is low again.
- R10: With `cfg_afull`=0, `busy` equals `full`. Otherwise `busy` is high while `fill_level` is at least `cfg_afull` or `full` is high, and triggers are still accepted while `busy` is high and `full` is low.
- R11: `wr_off` steps by one on each write and wraps from `WIN_LEN`-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nbuf | input | CNT_W | Number of event buffers, 1 to NBUF_MAX |
| cfg_spare | input | 1 | 1 selects spare-buffer full mode |
| cfg_afull | input | CNT_W | Busy level in filled buffers, 0 means busy follows full |
| cfg_post | input | POST_W | Post-trigger sample count, 1 to WIN_LEN |
| smp_valid | input | 1 | A sample is present this cycle |
| trig | input | 1 | Trigger request |
| rel | input | 1 | Release pulse for the oldest frozen buffer |
| trig_acc | output | 1 | Trigger accepted this cycle |
| wr_en | output | 1 | The present sample is written this cycle |
| wr_buf | output | IDX_W | Buffer being written |
| wr_off | output | OFF_W | Sample offset inside the buffer |
| rd_buf | output | IDX_W | Oldest frozen buffer |
| fill_level | output | CNT_W | Number of frozen buffers |
| ev_ready | output | 1 | At least one buffer is frozen |
| full | output | 1 | Trigger-blocking full condition |
| busy | output | 1 | Almost-full warning |

## Verification
A freeze from the post-trigger countdown and a release from the readout side can land in the same cycle. The bench provokes this by pulsing `rel` together with the last post-trigger sample while two buffers are already frozen. It judges the result one cycle later: `fill_level` must stay at 2, `rd_buf` must have moved on by one and `wr_buf` must have moved to the next buffer. In spare mode, a trigger that arrives with a release is also judged: it must be rejected in that cycle and a repeat in the next cycle must be accepted.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_HALT  = 2'd3
    } acq_state_t;
endpackage

// File: rtl/evbuf_acq_fsm.sv
module evbuf_acq_fsm
    import evbuf_pkg::*;
#(
    parameter int WIN_LEN = 16,
    localparam int OFF_W  = $clog2(WIN_LEN),
    localparam int POST_W = $clog2(WIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              trig,
    input  logic              full,
    input  logic              spare,
    input  logic [POST_W-1:0] cfg_post,
    output logic              wr_en,
    output logic              trig_acc,
    output logic              freeze,
    output logic [OFF_W-1:0]  wr_off
);
    localparam logic [POST_W-1:0] WIN_LAST = POST_W'(WIN_LEN - 1);
    localparam logic [OFF_W-1:0]  OFF_LAST = OFF_W'(WIN_LEN - 1);

    acq_state_t        state_q, state_d;
    logic [POST_W-1:0] win_q;
    logic [POST_W-1:0] post_q;
    logic [OFF_W-1:0]  off_q;
    logic              block;

    assign block  = full && !spare;
    assign wr_off = off_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        trig_acc = 1'b0;
        freeze   = 1'b0;
        unique case (state_q)
            ST_FILL:  wr_en = smp_valid && !block;
            ST_ARMED: begin
                wr_en    = smp_valid && !block;
                trig_acc = trig && !full;
            end
            ST_POST: begin
                wr_en  = smp_valid && !block;
                freeze = wr_en && (post_q == cfg_post - 1'b1);
            end
            ST_HALT: ;
        endcase
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (block)                          state_d = ST_HALT;
                else if (wr_en && win_q == WIN_LAST) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (block)         state_d = ST_HALT;
                else if (trig_acc) state_d = ST_POST;
            end
            ST_POST:  if (freeze) state_d = ST_ARMED;
            ST_HALT:  if (!full)  state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            win_q  <= '0;
            post_q <= '0;
        end else begin
            if (freeze)     off_q <= '0;
            else if (wr_en) off_q <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;

            if (state_q == ST_HALT)             win_q <= '0;
            else if (state_q == ST_FILL && wr_en) win_q <= win_q + 1'b1;

            if (trig_acc)                         post_q <= '0;
            else if (state_q == ST_POST && wr_en) post_q <= post_q + 1'b1;
        end
    end

    assert_post_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST && !freeze) |=> !trig_acc);
endmodule

// File: rtl/evbuf_ring.sv
module evbuf_ring #(
    parameter int NBUF_MAX = 1024,
    localparam int CNT_W   = $clog2(NBUF_MAX + 1),
    localparam int IDX_W   = $clog2(NBUF_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_nbuf,
    input  logic             freeze,
    input  logic             rel,
    output logic [CNT_W-1:0] level,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] wr_q, rd_q;
    logic             rel_ok;
    logic [CNT_W-1:0] last_idx;

    assign rel_ok   = rel && (cnt_q != '0);
    assign last_idx = cfg_nbuf - 1'b1;
    assign level    = cnt_q;
    assign wr_idx   = wr_q;
    assign rd_idx   = rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
        end else begin
            unique case ({freeze, rel_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (freeze) wr_q <= (CNT_W'(wr_q) == last_idx) ? '0 : wr_q + 1'b1;
            if (rel_ok) rd_q <= (CNT_W'(rd_q) == last_idx) ? '0 : rd_q + 1'b1;
        end
    end

    logic [CNT_W:0] ring_sum;
    logic [CNT_W:0] ring_pos;
    assign ring_sum = (CNT_W + 1)'(rd_q) + (CNT_W + 1)'(cnt_q);
    assign ring_pos = (ring_sum >= (CNT_W + 1)'(cfg_nbuf)) ?
                      ring_sum - (CNT_W + 1)'(cfg_nbuf) : ring_sum;

    assert_level_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cfg_nbuf);
    assert_ring_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_pos == (CNT_W + 1)'(wr_q));
endmodule

// File: rtl/evbuf_status.sv
module evbuf_status #(
    parameter int NBUF_MAX = 1024,
    localparam int CNT_W   = $clog2(NBUF_MAX + 1)
) (
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] cfg_nbuf,
    input  logic [CNT_W-1:0] cfg_afull,
    input  logic             cfg_spare,
    output logic             full,
    output logic             busy,
    output logic             ev_ready
);
    logic [CNT_W-1:0] full_mark;

    assign full_mark = cfg_spare ? cfg_nbuf - 1'b1 : cfg_nbuf;
    assign full      = (level >= full_mark);
    assign busy      = full || ((cfg_afull != '0) && (level >= cfg_afull));
    assign ev_ready  = (level != '0);
endmodule

// File: rtl/evbuf_mgr.sv
module evbuf_mgr #(
    parameter int NBUF_MAX = 1024,
    parameter int WIN_LEN  = 16,
    localparam int CNT_W   = $clog2(NBUF_MAX + 1),
    localparam int IDX_W   = $clog2(NBUF_MAX),
    localparam int OFF_W   = $clog2(WIN_LEN),
    localparam int POST_W  = $clog2(WIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_nbuf,
    input  logic              cfg_spare,
    input  logic [CNT_W-1:0]  cfg_afull,
    input  logic [POST_W-1:0] cfg_post,
    input  logic              smp_valid,
    input  logic              trig,
    input  logic              rel,
    output logic              trig_acc,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_buf,
    output logic [OFF_W-1:0]  wr_off,
    output logic [IDX_W-1:0]  rd_buf,
    output logic [CNT_W-1:0]  fill_level,
    output logic              ev_ready,
    output logic              full,
    output logic              busy
);
    logic freeze;

    evbuf_acq_fsm #(.WIN_LEN(WIN_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .trig      (trig),
        .full      (full),
        .spare     (cfg_spare),
        .cfg_post  (cfg_post),
        .wr_en     (wr_en),
        .trig_acc  (trig_acc),
        .freeze    (freeze),
        .wr_off    (wr_off)
    );

    evbuf_ring #(.NBUF_MAX(NBUF_MAX)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_nbuf (cfg_nbuf),
        .freeze   (freeze),
        .rel      (rel),
        .level    (fill_level),
        .wr_idx   (wr_buf),
        .rd_idx   (rd_buf)
    );

    evbuf_status #(.NBUF_MAX(NBUF_MAX)) u_status (
        .level     (fill_level),
        .cfg_nbuf  (cfg_nbuf),
        .cfg_afull (cfg_afull),
        .cfg_spare (cfg_spare),
        .full      (full),
        .busy      (busy),
        .ev_ready  (ev_ready)
    );

    assert_no_trig_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc |-> !full);
    assert_no_write_when_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !cfg_spare) |-> !wr_en);
    assert_refill_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_spare && $fell(full)) |=> !trig_acc);
    assert_spare_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cfg_spare && smp_valid) |-> wr_en);
endmodule

// File: tb/evbuf_mgr_bench.sv
module evbuf_mgr_bench;
    localparam int NBUF_MAX = 1024;
    localparam int WIN_LEN  = 16;
    localparam int CNT_W    = $clog2(NBUF_MAX + 1);
    localparam int IDX_W    = $clog2(NBUF_MAX);
    localparam int OFF_W    = $clog2(WIN_LEN);
    localparam int POST_W   = $clog2(WIN_LEN + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cfg_nbuf = '0;
    logic              cfg_spare = 1'b0;
    logic [CNT_W-1:0]  cfg_afull = '0;
    logic [POST_W-1:0] cfg_post = '0;
    logic              smp_valid = 1'b0;
    logic              trig = 1'b0;
    logic              rel = 1'b0;
    logic              trig_acc, wr_en, ev_ready, full, busy;
    logic [IDX_W-1:0]  wr_buf, rd_buf;
    logic [OFF_W-1:0]  wr_off;
    logic [CNT_W-1:0]  fill_level;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    evbuf_mgr #(.NBUF_MAX(NBUF_MAX), .WIN_LEN(WIN_LEN)) u_evbuf_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_nbuf(cfg_nbuf), .cfg_spare(cfg_spare),
        .cfg_afull(cfg_afull), .cfg_post(cfg_post), .smp_valid(smp_valid),
        .trig(trig), .rel(rel), .trig_acc(trig_acc), .wr_en(wr_en),
        .wr_buf(wr_buf), .wr_off(wr_off), .rd_buf(rd_buf),
        .fill_level(fill_level), .ev_ready(ev_ready), .full(full), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, then wait until just before the rising edge
    task automatic cyc(input logic v, input logic t, input logic r);
        @(negedge clk);
        smp_valid = v;
        trig      = t;
        rel       = r;
        #4;
    endtask

    task automatic expect_acc(input int b);
        exp_q.push_back(b);
    endtask

    task automatic do_reset(input int nb, input logic sp, input int af, input int pc);
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; trig = 1'b0; rel = 1'b0;
        cfg_nbuf = CNT_W'(nb); cfg_spare = sp; cfg_afull = CNT_W'(af); cfg_post = POST_W'(pc);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #4;
    endtask

    // monitor: every accepted trigger must match the next expected buffer
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (rst_n && trig_acc) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R2 unexpected trigger accept: actual buf %0d expected none", wr_buf);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (int'(wr_buf) != e) begin
                        n_err++;
                        $display("FAIL R3 accepted buffer: actual %0d expected %0d", wr_buf, e);
                    end
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int bad;
        // ---------- halting mode: 3 buffers, busy at 2, 4 post samples ----------
        do_reset(3, 1'b0, 2, 4);
        chk("R1", "fill_level", int'(fill_level), 0);
        chk("R1", "full", int'(full), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "ev_ready", int'(ev_ready), 0);
        chk("R1", "wr_buf", int'(wr_buf), 0);
        chk("R1", "rd_buf", int'(rd_buf), 0);

        for (int i = 0; i < 5; i++) begin
            cyc(1, 1, 0);
            chk("R2", "trig_acc during first window", int'(trig_acc), 0);
        end
        for (int i = 0; i < 10; i++) cyc(1, 0, 0);
        cyc(1, 0, 0);
        chk("R11", "wr_off at window end", int'(wr_off), WIN_LEN - 1);

        expect_acc(0);
        cyc(1, 1, 0);
        chk("R2", "trig_acc after window", int'(trig_acc), 1);
        chk("R11", "wr_off wrap", int'(wr_off), 0);

        cyc(1, 0, 0);
        cyc(1, 1, 0);
        chk("R4", "trig_acc during countdown", int'(trig_acc), 0);
        cyc(0, 0, 0);
        chk("R3", "wr_en on invalid sample", int'(wr_en), 0);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        chk("R3", "wr_buf on last post sample", int'(wr_buf), 0);
        chk("R3", "wr_off on last post sample", int'(wr_off), 4);

        expect_acc(1);
        cyc(1, 1, 0);
        chk("R3", "wr_buf after freeze", int'(wr_buf), 1);
        chk("R3", "wr_off after freeze", int'(wr_off), 0);
        chk("R3", "trig_acc right after freeze", int'(trig_acc), 1);
        chk("R5", "fill_level after freeze", int'(fill_level), 1);
        chk("R6", "ev_ready", int'(ev_ready), 1);
        chk("R6", "rd_buf oldest", int'(rd_buf), 0);
        chk("R10", "busy below level", int'(busy), 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);

        expect_acc(2);
        cyc(1, 1, 0);
        chk("R10", "busy at level", int'(busy), 1);
        chk("R10", "full while busy", int'(full), 0);
        chk("R10", "trig_acc while busy", int'(trig_acc), 1);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);

        cyc(1, 1, 0);
        chk("R7", "full at nbuf", int'(full), 1);
        chk("R7", "fill_level at nbuf", int'(fill_level), 3);
        chk("R7", "wr_en while full", int'(wr_en), 0);
        chk("R7", "trig_acc while full", int'(trig_acc), 0);
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            cyc(1, 1, 0);
            if (wr_en || trig_acc) bad++;
        end
        chk("R7", "writes or accepts while halted", bad, 0);

        cyc(1, 0, 1);
        chk("R8", "full in release cycle", int'(full), 1);
        cyc(1, 1, 0);
        chk("R8", "full after release", int'(full), 0);
        chk("R8", "wr_en as full falls", int'(wr_en), 0);
        chk("R8", "trig_acc as full falls", int'(trig_acc), 0);
        chk("R6", "rd_buf after release", int'(rd_buf), 1);
        chk("R5", "fill_level after release", int'(fill_level), 2);

        bad = 0;
        for (int i = 0; i < WIN_LEN; i++) begin
            cyc(1, 1, 0);
            if (trig_acc || !wr_en) bad++;
        end
        chk("R8", "refill cycles with accept or no write", bad, 0);
        expect_acc(0);
        cyc(1, 1, 0);
        chk("R8", "trig_acc after refill", int'(trig_acc), 1);

        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        cyc(1, 0, 1);   // last post sample together with a release
        cyc(1, 0, 0);
        chk("R5", "fill_level after freeze with release", int'(fill_level), 2);
        chk("R6", "rd_buf after freeze with release", int'(rd_buf), 2);
        chk("R3", "wr_buf wraps modulo nbuf", int'(wr_buf), 1);

        cyc(1, 0, 1);
        cyc(1, 0, 1);
        cyc(1, 0, 1);   // release while empty
        cyc(1, 0, 0);
        chk("R5", "fill_level after release at zero", int'(fill_level), 0);
        chk("R6", "rd_buf after release at zero", int'(rd_buf), 1);
        chk("R6", "ev_ready when empty", int'(ev_ready), 0);

        // ---------- spare mode: 2 buffers, busy follows full, 2 post samples ----------
        do_reset(2, 1'b1, 0, 2);
        for (int i = 0; i < WIN_LEN; i++) cyc(1, 0, 0);
        expect_acc(0);
        cyc(1, 1, 0);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        cyc(1, 1, 0);
        chk("R9", "full at nbuf-1", int'(full), 1);
        chk("R10", "busy equals full", int'(busy), 1);
        chk("R9", "trig_acc while spare full", int'(trig_acc), 0);
        chk("R9", "wr_en while spare full", int'(wr_en), 1);
        chk("R9", "wr_buf spare", int'(wr_buf), 1);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        cyc(1, 1, 1);
        chk("R9", "trig_acc in release cycle", int'(trig_acc), 0);
        expect_acc(1);
        cyc(1, 1, 0);
        chk("R9", "trig_acc right after release", int'(trig_acc), 1);
        chk("R10", "busy low with full low", int'(busy), 0);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        chk("R9", "full again", int'(full), 1);
        chk("R3", "wr_buf wraps to 0", int'(wr_buf), 0);

        cyc(0, 0, 0);
        chk("R2", "expected accepts left over", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule